// File: doc/BRIEF.md
# Configurable Single-Channel PWM Timer

This block drives one pulse-width-modulated output from a free-running counter and three software registers: a period, a duty value and a control word. Software loads the period and duty and sets the control word, which holds the run bit, repeat or single-pulse mode, the output level for each phase and left or centre placement of the pulse. It then writes zero to the counter to start a clean period. The counter advances by one on every clock while the run bit is set. It wraps to zero at the end of each period, and it can be read back or overwritten at any time.

The register port takes one word per cycle, addressed by word index. Word 0 is the counter, word 1 the period, word 2 the duty value and word 3 the control word. A read returns data in the same cycle. The output is decoded from the counter and the register state, with no extra pipeline stage.

Top module: `pwm_timer`

## Requirements
- R1: After reset the counter, period, duty and control registers read zero and `pwm_out` is low.
- R2: The register port uses word addresses 0 (counter), 1 (period), 2 (duty) and 3 (control). Period, duty and control read back the last value written. The counter reads the live count. A read returns data only while `req_valid` is high and `req_write` is low; otherwise `rd_data` is zero.
- R3: While control bit 0 is 1, the counter rises by one each clock. After the clock on which it holds period-1 or more, it becomes 0. A period of 0 or 1 keeps it at 0.
- R4: With control bit 5 at 0 (left placement), the output is in its active phase while count < duty. A duty of 0 is never active, and a duty of at least the period is always active.
- R5: With control bit 5 at 1 (centre placement), the output is active while lead <= count < lead+duty, where lead = floor((period-duty)/2). A duty of at least the period is always active.
- R6: Control bit 3 gives the output level in the active phase and bit 4 the level in the inactive phase.
- R7: With control bit 1 at 0 (single pulse), the block runs one period from the count it holds. On the wrap it clears control bit 0, and the output stays at the inactive level.
- R8: While control bit 0 is 0, the output equals control bit 4 and the counter holds its value.
- R9: A write to word 0 loads the counter on that clock and takes priority over counting and wrapping. Writing 0 restarts the period.
- R10: Control bit 8 is stored and read back but has no effect on the output or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle |
| pwm_out | output | 1 | PWM output |

## Verification
The scoreboard predicts the output and the live count on every cycle after a counter restart. It does this for left and centre placement, with an even and an odd gap between period and duty, and with both polarity pairs. A run with duty beyond the period and a run with zero duty separate strict from inclusive compares. A period of one exercises the smallest wrap. A counter load to a non-zero value shows that writes override counting. A single-pulse run distinguishes one period followed by a cleared run bit from a repeating run. Freezing tests and the low-power bit are checked against the same patterns, to show that the counter holds and that the bit changes nothing.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WADDR_W = 2;

  typedef enum logic [WADDR_W-1:0] {
    W_COUNT  = 2'd0,
    W_PERIOD = 2'd1,
    W_DUTY   = 2'd2,
    W_CTRL   = 2'd3
  } word_sel_e;

  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_REPEAT = 1;
  localparam int unsigned B_ACTLVL = 3;
  localparam int unsigned B_IDLLVL = 4;
  localparam int unsigned B_CENTRE = 5;
  localparam int unsigned B_LOWPWR = 8;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] live_cnt,
  input  logic              shot_done,
  output logic [DATA_W-1:0] period_q,
  output logic [DATA_W-1:0] duty_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              cnt_wr,
  output logic              ctrl_wr,
  output logic [DATA_W-1:0] rd_data
);
  logic wr_any;
  logic rd_any;

  assign wr_any  = req_valid && req_write;
  assign rd_any  = req_valid && !req_write;
  assign cnt_wr  = wr_any && (req_addr == W_COUNT);
  assign ctrl_wr = wr_any && (req_addr == W_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_any && req_addr == W_PERIOD) period_q <= req_wdata;
      if (wr_any && req_addr == W_DUTY)   duty_q   <= req_wdata;
      if (ctrl_wr)
        ctrl_q <= req_wdata;
      else if (shot_done)
        ctrl_q[B_RUN] <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_any) begin
      unique case (req_addr)
        W_COUNT:  rd_data = live_cnt;
        W_PERIOD: rd_data = period_q;
        W_DUTY:   rd_data = duty_q;
        default:  rd_data = ctrl_q;
      endcase
    end
  end
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              repeat_mode,
  input  logic [DATA_W-1:0] period,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt_q,
  output logic              at_end,
  output logic              shot_done
);
  function automatic logic end_of_period(input logic [DATA_W-1:0] c,
                                         input logic [DATA_W-1:0] p);
    if (p == '0) return 1'b1;
    return c >= (p - 1'b1);
  endfunction

  assign at_end    = end_of_period(cnt_q, period);
  assign shot_done = run && at_end && !repeat_mode && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run)
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_shape.sv
module pwm_shape #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              run,
  input  logic              centre,
  input  logic              act_lvl,
  input  logic              idl_lvl,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] period,
  input  logic [DATA_W-1:0] duty,
  output logic              in_active,
  output logic              pwm_out
);
  function automatic logic left_hit(input logic [DATA_W-1:0] c,
                                    input logic [DATA_W-1:0] d);
    return c < d;
  endfunction

  function automatic logic centre_hit(input logic [DATA_W-1:0] c,
                                      input logic [DATA_W-1:0] p,
                                      input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] lead;
    if (d >= p) return 1'b1;
    lead = (p - d) >> 1;
    return (c >= lead) && (c < lead + d);
  endfunction

  assign in_active = centre ? centre_hit(cnt, period, duty) : left_hit(cnt, duty);
  assign pwm_out   = (run && in_active) ? act_lvl : idl_lvl;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               pwm_out
);
  logic [DATA_W-1:0] period_w;
  logic [DATA_W-1:0] duty_w;
  logic [DATA_W-1:0] ctrl_w;
  logic [DATA_W-1:0] cnt_w;
  logic              cnt_wr_w;
  logic              ctrl_wr_w;
  logic              at_end_w;
  logic              shot_done_w;
  logic              in_active_w;
  logic              run_w;

  assign run_w = ctrl_w[B_RUN];

  pwm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .live_cnt(cnt_w), .shot_done(shot_done_w),
    .period_q(period_w), .duty_q(duty_w), .ctrl_q(ctrl_w),
    .cnt_wr(cnt_wr_w), .ctrl_wr(ctrl_wr_w), .rd_data(rd_data)
  );

  pwm_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .run(run_w), .repeat_mode(ctrl_w[B_REPEAT]),
    .period(period_w), .load(cnt_wr_w), .load_val(req_wdata),
    .cnt_q(cnt_w), .at_end(at_end_w), .shot_done(shot_done_w)
  );

  pwm_shape #(.DATA_W(DATA_W)) u_shape (
    .run(run_w), .centre(ctrl_w[B_CENTRE]),
    .act_lvl(ctrl_w[B_ACTLVL]), .idl_lvl(ctrl_w[B_IDLLVL]),
    .cnt(cnt_w), .period(period_w), .duty(duty_w),
    .in_active(in_active_w), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              repeat_mode,
  input logic              idl_lvl,
  input logic              at_end,
  input logic              cnt_wr,
  input logic              ctrl_wr,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] wdata,
  input logic              pwm_out
);
  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out == idl_lvl);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> cnt == $past(cnt));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end && !cnt_wr) |=> cnt == $past(cnt) + 1'b1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_end && !cnt_wr) |=> cnt == '0);

  p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_end && !repeat_mode && !cnt_wr && !ctrl_wr) |=> !run);

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));
endmodule

bind pwm_timer pwm_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .repeat_mode(ctrl_w[1]),
  .idl_lvl(ctrl_w[4]), .at_end(at_end_w), .cnt_wr(cnt_wr_w),
  .ctrl_wr(ctrl_wr_w), .cnt(cnt_w), .wdata(req_wdata), .pwm_out(pwm_out)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/100ps
module pwm_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic        lvl;
    logic [31:0] cnt;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  pwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one predicted item per cycle, 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " out"}, {31'd0, pwm_out}, {31'd0, it.lvl});
        check({it.tag, " cnt"}, rd_data, it.cnt);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_write = 1'b0; req_addr = 2'd0; req_wdata = '0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 check(tag, rd_data, exp);
    req_addr = 2'd0;
  endtask

  function automatic logic model_active(input int c, input int p, input int d, input bit ctr);
    int gap;
    if (!ctr) return c < d;
    if (d >= p) return 1'b1;
    gap = (p - d) / 2;
    return (c - gap >= 0) && (c - gap < d);
  endfunction

  // driver: predicts n cycles from a count of start, then waits for the monitor
  task automatic predict(input int p, input int d, input logic [31:0] ctl,
                         input int start, input int n, input string tag);
    int  c = start;
    bit  on = ctl[0];
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.cnt = c;
      it.lvl = (on && model_active(c, p, d, ctl[5])) ? ctl[3] : ctl[4];
      it.tag = tag;
      sb.push_back(it);
      if (on) begin
        if (p <= 1 || c >= p - 1) begin
          c = 0;
          if (!ctl[1]) on = 0;
        end else c = c + 1;
      end
    end
    wait (sb.size() == 0);
  endtask

  task automatic setup_run(input int p, input int d, input logic [31:0] ctl,
                           input int start, input int n, input string tag);
    wr(2'd1, p);
    wr(2'd2, d);
    wr(2'd3, ctl);
    wr(2'd0, start);
    predict(p, d, ctl, start, n, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v1;
    logic [31:0] v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 out", {31'd0, pwm_out}, 32'd0);
    rd_chk(2'd0, 0, "R1 count");
    rd_chk(2'd1, 0, "R1 period");
    rd_chk(2'd2, 0, "R1 duty");
    rd_chk(2'd3, 0, "R1 ctrl");
    // R2 map and readback
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'h0000_00AB);
    rd_chk(2'd1, 32'h1234_5678, "R2 period");
    rd_chk(2'd2, 32'h0000_00AB, "R2 duty");
    @(negedge clk); req_valid = 1'b0; #1 check("R2 no read", rd_data, 0);
    // R3 R4 left, repeat, active high
    setup_run(10, 3, 32'h0B, 0, 25, "R3R4 left");
    rd_chk(2'd3, 32'h0B, "R2 ctrl");
    // R6 inverted levels
    setup_run(10, 3, 32'h13, 0, 12, "R6 invert");
    // R5 centre, even and odd gap
    setup_run(10, 4, 32'h2B, 0, 20, "R5 centre even");
    setup_run(9, 4, 32'h2B, 0, 18, "R5 centre odd");
    setup_run(8, 9, 32'h2B, 0, 10, "R5 centre full");
    // R4 boundaries
    setup_run(10, 12, 32'h0B, 0, 12, "R4 duty over");
    setup_run(10, 0, 32'h0B, 0, 12, "R4 duty zero");
    // R3 period one
    setup_run(1, 1, 32'h0B, 0, 5, "R3 period one");
    // R10 low-power bit
    setup_run(10, 3, 32'h10B, 0, 12, "R10 lowpwr");
    rd_chk(2'd3, 32'h10B, "R10 ctrl");
    // R9 load non-zero
    setup_run(10, 3, 32'h0B, 6, 12, "R9 load");
    // R7 single pulse
    setup_run(6, 2, 32'h09, 0, 10, "R7 single");
    rd_chk(2'd3, 32'h08, "R7 ctrl cleared");
    check("R7 idle out", {31'd0, pwm_out}, 32'd0);
    // R8 disable freezes counter, output idle level
    setup_run(10, 9, 32'h0B, 0, 3, "R8 pre");
    wr(2'd3, 32'h1A);
    @(negedge clk); #1 v1 = rd_data;
    repeat (5) @(negedge clk);
    #1 v2 = rd_data;
    check("R8 frozen", v2, v1);
    check("R8 idle high", {31'd0, pwm_out}, 32'd1);
    wr(2'd3, 32'h0A);
    @(negedge clk); #1 check("R8 idle low", {31'd0, pwm_out}, 32'd0);
    check("R8 still frozen", rd_data, v1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule